// File: doc/BRIEF.md
# RTC status and interrupt control registers

This block holds the status and control state of a real-time clock. It keeps three sticky status flags. One records oscillator or data loss, one records that temperature compensation has halted, and one records a time-update event. The three condition sources outside the block report their events as one-cycle input pulses. Software reads the flags over a small synchronous register bus. It clears a flag by writing 0 to its bit. Writing 1 leaves the flag unchanged.

The control register holds a two-bit compensation interval select and a group of interrupt enable bits. From a 2 Hz tick enable, the block produces a one-cycle compensation-trigger pulse every 0.5 s, 2 s, 10 s or 30 s. The interrupt request is an open-drain, active-low output. It is presented as an output enable: 1 drives the pin low and 0 leaves it high-impedance. A separate power-up indication loads the defaults that follow a cold start from zero volts. The ordinary reset only restarts the interval generator.

Top module: `rtc_stat_ctrl`

## Requirements
- R1: The loss flag (status bit 0) becomes 1 in the cycle after a `loss_evt` pulse. It stays 1 until status is written with bit 0 = 0.
- R2: The compensation-halt flag (status bit 1) becomes 1 in the cycle after a `halt_evt` pulse. It stays 1 until status is written with bit 1 = 0.
- R3: Writing 1 to any status flag bit leaves that flag unchanged. Writing 0 clears it at the write's clock edge.
- R4: If a set event and a clearing write to the same flag fall in the same cycle, the flag ends at 1.
- R5: While `por` is high, both fault flags are set to 1, the update flag is cleared, and the interrupt enable output is cleared. The control register is loaded so that bits 7:6 = 01 and bit 2 = bit 1 = 0.
- R6: Control bits 7:6 select 1, 4, 20 or 60 ticks (codes 00, 01, 10, 11) between trigger pulses. `comp_trig` is high for exactly the one cycle after the clock edge that samples the final tick of each period.
- R7: Any write to the control register restarts the tick count, so the next pulse needs a full period of ticks after the write.
- R8: An `upd_evt` pulse while control bit 5 = 1 raises `irq_oe` in the next cycle. `irq_oe` stays 1 until status is written with bit 2 = 0.
- R9: An `upd_evt` pulse while control bit 5 = 0 leaves `irq_oe` at 0. Setting bit 5 afterwards does not raise `irq_oe` for the event already recorded.
- R10: The update flag (status bit 2) becomes 1 after `upd_evt` whatever the enable is, and it is sticky like the fault flags.
- R11: Write-protected positions read 0: status bits 7:3, control bit 0, and every unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the interval generator |
| por | input | 1 | Power-up-from-zero-volts indication; loads flag and control defaults |
| tick_2hz | input | 1 | One-cycle enable at 2 Hz |
| loss_evt | input | 1 | Oscillation/data loss event pulse |
| halt_evt | input | 1 | Temperature compensation halt event pulse |
| upd_evt | input | 1 | Time update event pulse |
| bus_addr | input | ADDR_W | Register address (status at 0, control at 1) |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| comp_trig | output | 1 | One-cycle compensation trigger pulse |
| irq_oe | output | 1 | Interrupt pin drive enable (1 = pull low, 0 = high-impedance) |

## Verification
The interval generator is swept across all four select codes. Each code runs two consecutive periods, and every tick is checked for the presence or absence of a pulse. This separates an off-by-one count, a wrong code-to-length mapping and a count that fails to wrap. A partial count followed by a control write shows whether the restart happens. Each flag is hit with a set pulse, a write of 1, a write of 0, and a set coinciding with a clear. These patterns tell apart sticky behaviour, write-one immunity and the set-wins priority. The interrupt path is tried with the enable on, with it off, and with it turned on after an event, to show that the request follows the event edge and not the flag level.

// File: rtl/rtc_stat_ctrl.sv
module rtc_stat_ctrl #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 1,
  parameter int TICKS_0 = 1,
  parameter int TICKS_1 = 4,
  parameter int TICKS_2 = 20,
  parameter int TICKS_3 = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por,
  input  logic              tick_2hz,
  input  logic              loss_evt,
  input  logic              halt_evt,
  input  logic              upd_evt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  output logic [7:0]        bus_rdata,
  output logic              comp_trig,
  output logic              irq_oe
);
  localparam int CNT_W = $clog2(TICKS_3 + 1);

  logic             loss_q, halt_q, upd_q;
  logic [7:1]       ctrl_q;
  logic [CNT_W-1:0] cnt_q, last;

  wire wr_stat = bus_wr && (bus_addr == STAT_ADDR);
  wire wr_ctrl = bus_wr && (bus_addr == CTRL_ADDR);
  wire upd_ie  = ctrl_q[5];

  always_ff @(posedge clk) begin
    if (por) begin
      loss_q <= 1'b1;
      halt_q <= 1'b1;
      upd_q  <= 1'b0;
      irq_oe <= 1'b0;
      ctrl_q <= 7'b0100000;
    end else begin
      loss_q <= loss_evt | (loss_q & ~(wr_stat & ~bus_wdata[0]));
      halt_q <= halt_evt | (halt_q & ~(wr_stat & ~bus_wdata[1]));
      upd_q  <= upd_evt  | (upd_q  & ~(wr_stat & ~bus_wdata[2]));
      if (upd_evt && upd_ie)
        irq_oe <= 1'b1;
      else if (wr_stat && !bus_wdata[2])
        irq_oe <= 1'b0;
      if (wr_ctrl)
        ctrl_q <= bus_wdata[7:1];
    end
  end

  always_comb begin
    case (ctrl_q[7:6])
      2'd0:    last = CNT_W'(TICKS_0 - 1);
      2'd1:    last = CNT_W'(TICKS_1 - 1);
      2'd2:    last = CNT_W'(TICKS_2 - 1);
      default: last = CNT_W'(TICKS_3 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || por) begin
      cnt_q     <= '0;
      comp_trig <= 1'b0;
    end else begin
      comp_trig <= 1'b0;
      if (wr_ctrl)
        cnt_q <= '0;
      else if (tick_2hz) begin
        if (cnt_q >= last) begin
          cnt_q     <= '0;
          comp_trig <= 1'b1;
        end else
          cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (bus_addr == STAT_ADDR)
      bus_rdata = {5'b0, upd_q, halt_q, loss_q};
    else if (bus_addr == CTRL_ADDR)
      bus_rdata = {ctrl_q, 1'b0};
    else
      bus_rdata = 8'h00;
  end

  // R1
  loss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || por)
    (loss_q && !(wr_stat && !bus_wdata[0])) |=> loss_q);
  // R3
  write_one_chk: assert property (@(posedge clk) disable iff (!rst_n || por)
    (wr_stat && bus_wdata[1] && halt_q) |=> halt_q);
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n || por)
    loss_evt |=> loss_q);
  // R5
  por_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por |=> (loss_q && halt_q && !irq_oe && ctrl_q[7:6] == 2'b01));
  // R6
  trig_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n || por)
    comp_trig |-> $past(tick_2hz));
  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n || por)
    wr_ctrl |=> !comp_trig);
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || por)
    $rose(irq_oe) |-> $past(upd_evt && upd_ie));
endmodule

// File: tb/rtc_stat_ctrl_tb.sv
module rtc_stat_ctrl_tb;
  logic clk = 0, rst_n = 0, por = 1, tick = 0;
  logic loss_evt = 0, halt_evt = 0, upd_evt = 0, wr = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic comp_trig, irq_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_stat_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .por(por), .tick_2hz(tick),
    .loss_evt(loss_evt), .halt_evt(halt_evt), .upd_evt(upd_evt),
    .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr),
    .bus_rdata(rdata), .comp_trig(comp_trig), .irq_oe(irq_oe));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  function automatic int period(int sel);
    case (sel)
      0: return 1;
      1: return 4;
      2: return 20;
      default: return 60;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    por = 0; rst_n = 1;
    @(negedge clk);
    rd_reg(0, d); chk("R5 status after power-up", d, 8'h03);
    rd_reg(1, d); chk("R5 control defined bits", d & 8'hC7, 8'h40);
    chk("R5 irq after power-up", irq_oe, 0);
    chk("R5 trig after power-up", comp_trig, 0);
    rd_reg(5, d); chk("R11 unmapped address", d, 0);

    wr_reg(0, 8'hFF);
    rd_reg(0, d); chk("R3 write one keeps flags", d, 8'h03);
    wr_reg(0, 8'hFE);
    rd_reg(0, d); chk("R3 clear loss only", d, 8'h02);
    wr_reg(0, 8'hFD);
    rd_reg(0, d); chk("R2 clear halt", d, 8'h00);

    @(negedge clk); loss_evt = 1; @(negedge clk); loss_evt = 0;
    repeat (3) @(negedge clk);
    rd_reg(0, d); chk("R1 loss set and held", d, 8'h01);
    @(negedge clk); halt_evt = 1; @(negedge clk); halt_evt = 0;
    rd_reg(0, d); chk("R2 halt set", d, 8'h03);

    @(negedge clk); addr = 0; wdata = 8'h00; wr = 1; loss_evt = 1;
    @(negedge clk); wr = 0; loss_evt = 0;
    rd_reg(0, d); chk("R4 set beats clear", d, 8'h01);
    wr_reg(0, 8'h00);

    wr_reg(1, 8'hFF);
    rd_reg(1, d); chk("R11 control bit0 reads zero", d & 8'h01, 0);
    wr_reg(0, 8'hF8);
    rd_reg(0, d); chk("R11 status upper bits zero", d, 0);

    wr_reg(1, 8'h60);
    @(negedge clk); upd_evt = 1; @(negedge clk); upd_evt = 0;
    chk("R8 irq after enabled event", irq_oe, 1);
    rd_reg(0, d); chk("R10 update flag set", d, 8'h04);
    wr_reg(0, 8'hFF);
    chk("R8 irq held after write one", irq_oe, 1);
    wr_reg(0, 8'hFB);
    chk("R8 irq released by clear", irq_oe, 0);
    rd_reg(0, d); chk("R10 update flag cleared", d, 0);

    wr_reg(1, 8'h40);
    @(negedge clk); upd_evt = 1; @(negedge clk); upd_evt = 0;
    chk("R9 no irq when disabled", irq_oe, 0);
    rd_reg(0, d); chk("R10 flag set while disabled", d, 8'h04);
    wr_reg(1, 8'h60);
    repeat (2) @(negedge clk);
    chk("R9 late enable no irq", irq_oe, 0);
    wr_reg(0, 8'h00);

    for (int sel = 0; sel < 4; sel++) begin
      wr_reg(1, 8'(sel << 6));
      for (int p = 0; p < 2; p++)
        for (int k = 1; k <= period(sel); k++) begin
          do_tick();
          chk($sformatf("R6 sel=%0d tick=%0d", sel, k), comp_trig, (k == period(sel)) ? 1 : 0);
          @(negedge clk);
          chk("R6 pulse one cycle", comp_trig, 0);
        end
    end

    wr_reg(1, 8'h40);
    do_tick(); do_tick();
    wr_reg(1, 8'h40);
    for (int k = 1; k <= 4; k++) begin
      do_tick();
      chk($sformatf("R7 restart tick=%0d", k), comp_trig, (k == 4) ? 1 : 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule